// File: doc/BRIEF.md
# Multi-CPU Prioritized Interrupt Acceptor

This block sits beside a group of processors and decides, for each of them, which interrupt to take next. Every processor sees 24 priority levels, and a lower level number means higher priority. Levels 0 to 10 belong to a single processor. They come from its own request lines, and an interprocessor signal from another CPU can also raise one of them. These levels are always honoured. Levels 11 to 23 are external requests. They are broadcast to every processor, and each processor can shut them out with its own lockout input.

A request pulse sets a pending bit. On each cycle, every processor picks its lowest-numbered eligible pending level. If that level is one of its own, it takes it at once. If it is a shared external level, the processor raises a claim on a single shared token. Only one claimant gets the token in a cycle, and the lowest CPU index wins a tie. The winner takes the level, and the shared pending bit is cleared on that same edge. Processors that lose the token take nothing in that cycle and try again on the next one. When a processor takes a level, its take strobe is high for one cycle and the accepted level is shown on its take level output. Saving processor state belongs to the consumer of these strobes.

Top module: `intacc_cluster`

## Requirements
- R1: After reset no level is pending, and `take_o`, `claim_o` and `grant_o` are all zero.
- R2: A one-cycle pulse on a request line sets that level pending at the next edge. The CPU's `take_o` bit is high for exactly one cycle at the edge after that, with the level number on its 5-bit field of `take_lvl_o` (bits [5c+4:5c] for CPU c).
- R3: Levels 0–10 are private to each CPU. Bit 11·c+L of `int_req_i` raises level L on CPU c. These levels are taken even while that CPU's `lockout_i` bit is high.
- R4: Bit j of `ext_req_i` raises external level 11+j, and every CPU sees it. A CPU whose `lockout_i` bit is high neither claims nor takes levels 11–23. Such a request stays pending until a CPU without lockout takes it.
- R5: When several CPUs claim in the same cycle, only the lowest-indexed claimant is granted. Exactly one CPU takes each external request, and the others take nothing in that cycle.
- R6: A taken external level is cleared on the edge that takes it, so no CPU takes it a second time.
- R7: When several levels are eligible for a CPU, it takes the lowest-numbered one first, at most one per cycle. The rest are taken in later cycles in ascending level order. An internal level always beats an external level.
- R8: If `ipi_send_i[s]` is high while `ipi_dest_i[2s+1:2s]` holds t, level 10 is raised on CPU t. Lockout does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req_i | input | 44 | Per-CPU internal request pulses, 11 per CPU |
| ext_req_i | input | 13 | Broadcast external request pulses for levels 11–23 |
| lockout_i | input | 4 | Per-CPU lockout of levels 11–23 |
| ipi_send_i | input | 4 | Per-CPU interprocessor interrupt send strobe |
| ipi_dest_i | input | 8 | Per-sender target CPU index, 2 bits each |
| take_o | output | 4 | Per-CPU take strobe |
| take_lvl_o | output | 20 | Per-CPU accepted level, 5 bits each |
| claim_o | output | 4 | Per-CPU claim on the shared token |
| grant_o | output | 4 | Per-CPU token grant (claim acknowledge) |

## Verification
There is one register between a request pulse and the pending bit, and one more between the pending bit and the take strobe. A take is therefore due on the second rising edge after the pulse edge. Every input is driven on a falling edge, and every check samples on the falling edge after the edge on which a result is due. Later levels of a burst are expected one per edge after the first, and the bench checks each of them on its own falling edge. Negative checks are made on the edges where a take would appear if lockout or clearing were broken, so absence is observed on exactly those edges.

// File: rtl/intacc_pkg.sv
package intacc_pkg;

    localparam int unsigned LVL_BITS = 5;
    localparam int unsigned VEC_MAX  = 32;

    typedef logic [LVL_BITS-1:0] lvl_t;

    typedef struct packed {
        logic vld;
        lvl_t lvl;
    } pick_t;

    // lowest set bit among the first n bits of v
    function automatic pick_t lowest_of(input logic [VEC_MAX-1:0] v,
                                        input int unsigned n);
        pick_t r;
        r = '0;
        for (int i = VEC_MAX - 1; i >= 0; i--) begin
            if (i < int'(n) && v[i]) begin
                r.vld = 1'b1;
                r.lvl = lvl_t'(i);
            end
        end
        return r;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/intacc_claim.sv
module intacc_claim
    import intacc_pkg::*;
#(
    parameter int unsigned NCPU = 4,
    parameter int unsigned NINT = 11,
    parameter int unsigned NEXT = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] ext_req_i,
    input  logic [NCPU-1:0] claim_i,
    input  lvl_t            claim_lvl_i [NCPU],
    output logic [NCPU-1:0] grant_o,
    output logic [NEXT-1:0] ext_pend_o
);

    logic [NEXT-1:0] pend_q;
    logic [NEXT-1:0] clr_mask;

    // single token: lowest claimant index wins
    always_comb begin
        grant_o  = '0;
        clr_mask = '0;
        for (int c = NCPU - 1; c >= 0; c--) begin
            if (claim_i[c]) begin
                grant_o  = '0;
                grant_o[c] = 1'b1;
                clr_mask = '0;
                for (int j = 0; j < int'(NEXT); j++) begin
                    if (int'(claim_lvl_i[c]) == j + int'(NINT)) clr_mask[j] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q & ~clr_mask) | ext_req_i;
    end

    assign ext_pend_o = pend_q;

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R5
    grant_claim_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~claim_i) == '0);

    // R6
    clear_taken_chk: assert property (@(posedge clk) disable iff (rst)
        ((|grant_o) && ((ext_req_i & clr_mask) == '0))
        |=> ((pend_q & $past(clr_mask)) == '0));

endmodule

// File: rtl/intacc_cpu.sv
module intacc_cpu
    import intacc_pkg::*;
#(
    parameter int unsigned NLVL = 24,
    parameter int unsigned NINT = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NINT-1:0]      int_set_i,
    input  logic [NLVL-NINT-1:0] ext_pend_i,
    input  logic                 lockout_i,
    input  logic                 grant_i,
    output logic                 claim_o,
    output lvl_t                 claim_lvl_o,
    output logic                 take_o,
    output lvl_t                 take_lvl_o
);

    localparam int unsigned NEXT = NLVL - NINT;

    logic [NINT-1:0]    int_pend_q;
    logic [VEC_MAX-1:0] cand;
    pick_t              best;
    logic               best_int;
    logic               take_now;
    logic [NINT-1:0]    int_clr;

    always_comb begin
        cand = '0;
        cand[NINT-1:0]    = int_pend_q;
        cand[NLVL-1:NINT] = ext_pend_i & {NEXT{~lockout_i}};
    end

    assign best     = lowest_of(cand, NLVL);
    assign best_int = best.vld && (int'(best.lvl) < int'(NINT));
    assign claim_o  = best.vld && !best_int;
    assign claim_lvl_o = best.lvl;
    assign take_now = best_int || (claim_o && grant_i);

    always_comb begin
        int_clr = '0;
        for (int i = 0; i < int'(NINT); i++) begin
            if (best_int && int'(best.lvl) == i) int_clr[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_pend_q <= '0;
            take_o     <= 1'b0;
            take_lvl_o <= '0;
        end else begin
            int_pend_q <= (int_pend_q & ~int_clr) | int_set_i;
            take_o     <= take_now;
            take_lvl_o <= take_now ? best.lvl : '0;
        end
    end

    // R4
    lock_no_claim_chk: assert property (@(posedge clk) disable iff (rst)
        lockout_i |-> !claim_o);

    // R3
    int_always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (int_pend_q != '0) |=> (take_o && int'(take_lvl_o) < int'(NINT)));

    // R2
    take_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(cand != '0));

endmodule

// File: rtl/intacc_cluster.sv
module intacc_cluster
    import intacc_pkg::*;
#(
    parameter int unsigned NCPU = 4,
    parameter int unsigned NLVL = 24,
    parameter int unsigned NINT = 11,
    localparam int unsigned NEXT = NLVL - NINT,
    localparam int unsigned CPUW = idx_width(NCPU)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCPU*NINT-1:0]     int_req_i,
    input  logic [NEXT-1:0]          ext_req_i,
    input  logic [NCPU-1:0]          lockout_i,
    input  logic [NCPU-1:0]          ipi_send_i,
    input  logic [NCPU*CPUW-1:0]     ipi_dest_i,
    output logic [NCPU-1:0]          take_o,
    output logic [NCPU*LVL_BITS-1:0] take_lvl_o,
    output logic [NCPU-1:0]          claim_o,
    output logic [NCPU-1:0]          grant_o
);

    localparam int unsigned IPI_LVL = NINT - 1;

    logic [NCPU-1:0] ipi_hit;
    logic [NEXT-1:0] ext_pend;
    lvl_t            claim_lvl [NCPU];

    // interprocessor interrupt routing
    always_comb begin
        ipi_hit = '0;
        for (int s = 0; s < int'(NCPU); s++) begin
            if (ipi_send_i[s]) ipi_hit[ipi_dest_i[s*CPUW +: CPUW]] = 1'b1;
        end
    end

    intacc_claim #(.NCPU(NCPU), .NINT(NINT), .NEXT(NEXT)) u_claim (
        .clk        (clk),
        .rst        (rst),
        .ext_req_i  (ext_req_i),
        .claim_i    (claim_o),
        .claim_lvl_i(claim_lvl),
        .grant_o    (grant_o),
        .ext_pend_o (ext_pend)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NINT-1:0] int_set;
        lvl_t            tlvl;

        always_comb begin
            int_set = int_req_i[c*NINT +: NINT];
            int_set[IPI_LVL] = int_set[IPI_LVL] | ipi_hit[c];
        end

        intacc_cpu #(.NLVL(NLVL), .NINT(NINT)) u_cpu (
            .clk        (clk),
            .rst        (rst),
            .int_set_i  (int_set),
            .ext_pend_i (ext_pend),
            .lockout_i  (lockout_i[c]),
            .grant_i    (grant_o[c]),
            .claim_o    (claim_o[c]),
            .claim_lvl_o(claim_lvl[c]),
            .take_o     (take_o[c]),
            .take_lvl_o (tlvl)
        );

        assign take_lvl_o[c*LVL_BITS +: LVL_BITS] = tlvl;
    end

    // R5
    ext_take_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_o) <= 1);

endmodule

// File: tb/intacc_cluster_bench.sv
module intacc_cluster_bench;

    localparam int NCPU = 4;
    localparam int NINT = 11;
    localparam int NEXT = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCPU*NINT-1:0] int_req = '0;
    logic [NEXT-1:0]  ext_req = '0;
    logic [NCPU-1:0]  lockout = '0;
    logic [NCPU-1:0]  ipi_send = '0;
    logic [NCPU*2-1:0] ipi_dest = '0;
    logic [NCPU-1:0]  take;
    logic [NCPU*5-1:0] take_lvl;
    logic [NCPU-1:0]  claim;
    logic [NCPU-1:0]  grant;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    intacc_cluster u_intacc_cluster (
        .clk       (clk),
        .rst       (rst),
        .int_req_i (int_req),
        .ext_req_i (ext_req),
        .lockout_i (lockout),
        .ipi_send_i(ipi_send),
        .ipi_dest_i(ipi_dest),
        .take_o    (take),
        .take_lvl_o(take_lvl),
        .claim_o   (claim),
        .grant_o   (grant)
    );

    task automatic chk(input logic [3:0] em, input int l0, input int l1,
                       input int l2, input int l3, input string tag);
        int el [4];
        logic ok;
        el[0] = l0; el[1] = l1; el[2] = l2; el[3] = l3;
        ok = (take === em);
        for (int c = 0; c < NCPU; c++)
            if (em[c] && int'(take_lvl[c*5 +: 5]) != el[c]) ok = 1'b0;
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: take=%b lvls=%h expected take=%b lvls=%0d,%0d,%0d,%0d",
                     tag, take, take_lvl, em, l0, l1, l2, l3);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one-cycle pulse on whatever request bits are currently set
    task automatic release_reqs();
        step();
        int_req  = '0;
        ext_req  = '0;
        ipi_send = '0;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        n_chk++;
        if (take !== '0 || claim !== '0 || grant !== '0) begin
            n_bad++;
            $display("FAIL R1: take=%b claim=%b grant=%b expected all 0", take, claim, grant);
        end

        // R2 R3 sweep every internal level on every CPU, lockout on
        lockout = '1;
        for (int c = 0; c < NCPU; c++) begin
            for (int l = 0; l < NINT; l++) begin
                int_req[c*NINT + l] = 1'b1;
                release_reqs();
                step();
                chk(4'(1 << c), l, l, l, l, "R3 internal level taken");
                step();
                chk(4'b0, 0, 0, 0, 0, "R2 strobe lasts one cycle");
            end
        end
        lockout = '0;

        // R5 R6 sweep external levels: all claim, CPU0 wins, taken once
        for (int l = NINT; l < NINT + NEXT; l++) begin
            ext_req[l - NINT] = 1'b1;
            release_reqs();
            step();
            chk(4'b0001, l, 0, 0, 0, "R5 lowest claimant takes external");
            step();
            chk(4'b0, 0, 0, 0, 0, "R6 external not taken twice");
        end

        // R7 priority order, internal beats external
        int_req[0*NINT + 5] = 1'b1;
        int_req[0*NINT + 3] = 1'b1;
        ext_req[1] = 1'b1;                // level 12
        release_reqs();
        step();
        chk(4'b0011, 3, 12, 0, 0, "R7 cpu0 takes 3, cpu1 wins level 12");
        step();
        chk(4'b0001, 5, 0, 0, 0, "R7 cpu0 takes 5 next");
        step();
        chk(4'b0, 0, 0, 0, 0, "R7 nothing left");

        // R4 lockout holds external pending
        lockout = 4'b1111;
        ext_req[4] = 1'b1;                // level 15
        release_reqs();
        for (int k = 0; k < 4; k++) begin
            step();
            chk(4'b0, 0, 0, 0, 0, "R4 locked out, no take");
        end
        int_req[2*NINT + 7] = 1'b1;
        release_reqs();
        step();
        chk(4'b0100, 0, 0, 7, 0, "R3 internal taken during lockout");
        lockout = 4'b0111;
        step();
        chk(4'b1000, 0, 0, 0, 15, "R4 unlocked cpu3 takes pending 15");
        step();
        chk(4'b0, 0, 0, 0, 0, "R6 level 15 cleared");

        // R5 R7 two externals, cpu0 locked: cpu1 wins both in order
        lockout = 4'b0001;
        ext_req[0] = 1'b1;                // level 11
        ext_req[3] = 1'b1;                // level 14
        release_reqs();
        step();
        chk(4'b0010, 0, 11, 0, 0, "R5 cpu1 takes 11, cpu2/3 lose");
        step();
        chk(4'b0010, 0, 14, 0, 0, "R7 cpu1 takes 14 next");
        step();
        chk(4'b0, 0, 0, 0, 0, "R6 both cleared");

        // R8 interprocessor interrupt, under lockout
        lockout = 4'b1111;
        for (int s = 0; s < NCPU; s++) begin
            ipi_send[s] = 1'b1;
            ipi_dest[s*2 +: 2] = 2'((s + 2) % NCPU);
            release_reqs();
            step();
            chk(4'(1 << ((s + 2) % NCPU)), 10, 10, 10, 10, "R8 ipi raises level 10");
        end
        lockout = '0;
        step();
        chk(4'b0, 0, 0, 0, 0, "R8 ipi taken once");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule